// File: doc/BRIEF.md
# Fused multiply-add alignment, addition and normalization core

This block is the arithmetic middle of a single-precision fused multiply-add. It handles the case where the product x*y is finite and nonzero. Each operand comes in as an unbiased signed exponent, a 24-bit significand with its hidden bit already set, and a sign bit. A flag marks z as zero, and a mode bit selects round-toward-minus-infinity. The block forms the exact 48-bit product, lines it up against z in a 64-bit working word, adds or subtracts, and renormalizes. It returns a sign, an exponent and a 27-bit significand: 24 bits followed by guard, round and sticky. A separate rounding and packing stage consumes this result.

Every bit that a right shift drops is ORed into the word's least significant bit. The result therefore carries enough information for correct rounding later. A zero flag marks an exact cancellation, so the packer can emit a signed zero directly.

One operation is accepted per cycle through a valid/ready handshake. The result is registered, and it is held stable while the consumer stalls.

Top module: `fma_aan_core`

## Requirements
- R1: The product exponent is x_exp_i + y_exp_i. The 48-bit significand product is placed at the top of a 64-bit word. If bit 63 is then set, the word shifts right by one and the exponent rises by one, so the leading one always sits at bit 62.
- R2: With z_zero_i high, the result is the product alone. Its sign is x_neg_i XOR y_neg_i and its exponent is the product exponent from R1. sig_o is word bits 62..36, with bit 0 ORed with every lower bit.
- R3: z's significand is placed with its hidden bit at bit 62. The operand with the smaller exponent shifts right by the exponent difference, and any dropped 1 bits set bit 0. The working exponent is the larger of the two.
- R4: An alignment shift of 63 or more reduces the shifted operand to the value 1, a lone sticky bit.
- R5: When z_neg_i equals the product sign, the aligned values are added. A carry into bit 63 shifts the sum right by one with sticky and increments the exponent.
- R6: When the signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger, with z's sign used on a tie.
- R7: An exact zero difference gives zero_o=1, sig_o=0, exp_o=0 and sign_o=rdn_i.
- R8: A nonzero difference is shifted left until bit 62 is set, and the exponent drops by one per position. Every valid nonzero result has sig_o[26]=1.
- R9: in_ready_o equals !out_valid_o || out_ready_i. While out_valid_o is high and out_ready_i is low, the output holds valid and unchanged on the next cycle.
- R10: After reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation accepted when high with in_valid_i |
| x_neg_i | input | 1 | Sign of x |
| x_exp_i | input | 12 | Unbiased exponent of x, two's complement |
| x_sig_i | input | 24 | Significand of x, hidden bit set |
| y_neg_i | input | 1 | Sign of y |
| y_exp_i | input | 12 | Unbiased exponent of y |
| y_sig_i | input | 24 | Significand of y, hidden bit set |
| z_neg_i | input | 1 | Effective sign of z |
| z_exp_i | input | 12 | Unbiased exponent of z |
| z_sig_i | input | 24 | Significand of z, hidden bit set |
| z_zero_i | input | 1 | z is zero |
| rdn_i | input | 1 | Round-down mode, sets the sign of an exact zero |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts the result |
| sign_o | output | 1 | Result sign |
| exp_o | output | 12 | Result exponent, two's complement |
| sig_o | output | 27 | 24-bit significand plus guard, round and sticky |
| zero_o | output | 1 | Result is an exact zero |

## Verification
The bench first targets the two product normalization paths, including the all-ones significand product. A core that skipped the bit-63 correction would return an exponent one low and a significand with its top bit lost.

It then probes alignment distances of 62, 63 and well above. A shifter without saturation or sticky collection would drop the far operand entirely or wrap the shift amount, and the low rounding bits would then be wrong.

Exact cancellation is tested in both rounding modes, along with deep cancellation down to a one-LSB difference. These expose a wrong zero sign or a normalizer that miscounts leading zeros, which would show up as a wrong exponent.

Finally, random operands run under random consumer stalls, to catch results that change, get lost or get duplicated while the output is held.

// File: rtl/fma_pkg.sv
package fma_pkg;
  parameter int unsigned SIG_W  = 24;
  parameter int unsigned EXP_W  = 12;
  parameter int unsigned WORD_W = 64;
  parameter int unsigned GRS_W  = 3;

  localparam int unsigned OUT_W     = SIG_W + GRS_W;
  localparam int unsigned LEAD      = WORD_W - 2;
  localparam int unsigned OUT_SHIFT = LEAD - (OUT_W - 1);
  localparam int unsigned Z_SHIFT   = LEAD - (SIG_W - 1);
  localparam int unsigned AMT_W     = EXP_W + 1;
  localparam int unsigned LZ_W      = $clog2(WORD_W);

  typedef logic [WORD_W-1:0]       word_t;
  typedef logic signed [EXP_W-1:0] exp_t;

  typedef struct packed {
    logic             sign;
    exp_t             exp;
    logic [OUT_W-1:0] sig;
    logic             zero;
  } res_t;
endpackage

// File: rtl/fma_prod.sv
module fma_prod
  import fma_pkg::*;
(
  input  logic [SIG_W-1:0] x_sig_i,
  input  logic [SIG_W-1:0] y_sig_i,
  input  exp_t             x_exp_i,
  input  exp_t             y_exp_i,
  output word_t            prod_o,
  output exp_t             exp_o
);
  logic [2*SIG_W-1:0] mul;
  word_t              raw;

  always_comb begin
    mul = x_sig_i * y_sig_i;
    raw = {mul, {(WORD_W-2*SIG_W){1'b0}}};
    if (raw[WORD_W-1]) begin
      prod_o = raw >> 1;
      exp_o  = x_exp_i + y_exp_i + exp_t'(1);
    end else begin
      prod_o = raw;
      exp_o  = x_exp_i + y_exp_i;
    end
  end
endmodule

// File: rtl/fma_sticky_shr.sv
module fma_sticky_shr #(
  parameter int unsigned W  = 64,
  parameter int unsigned AW = 13
) (
  input  logic [W-1:0]  v_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  v_o
);
  logic [W-1:0] mask;

  always_comb begin
    mask = '0;
    if (amt_i >= AW'(W-1)) begin
      v_o = {{(W-1){1'b0}}, |v_i};
    end else begin
      mask = ~({W{1'b1}} << amt_i);
      v_o  = (v_i >> amt_i) | {{(W-1){1'b0}}, |(v_i & mask)};
    end
  end
endmodule

// File: rtl/fma_lzc.sv
module fma_lzc #(
  parameter int unsigned W  = 63,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v_i,
  output logic [CW-1:0] cnt_o
);
  logic found;

  always_comb begin
    cnt_o = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (v_i[i]) found = 1'b1;
        else        cnt_o = cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fma_aan_core.sv
module fma_aan_core
  import fma_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic                x_neg_i,
  input  logic [EXP_W-1:0]    x_exp_i,
  input  logic [SIG_W-1:0]    x_sig_i,
  input  logic                y_neg_i,
  input  logic [EXP_W-1:0]    y_exp_i,
  input  logic [SIG_W-1:0]    y_sig_i,
  input  logic                z_neg_i,
  input  logic [EXP_W-1:0]    z_exp_i,
  input  logic [SIG_W-1:0]    z_sig_i,
  input  logic                z_zero_i,
  input  logic                rdn_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                sign_o,
  output logic [EXP_W-1:0]    exp_o,
  output logic [OUT_W-1:0]    sig_o,
  output logic                zero_o
);
  word_t            prod_w, z_w, pa, za, sum, dif, norm, w_sel;
  exp_t             pe, ae, e_sel;
  logic signed [EXP_W:0] diff;
  logic [AMT_W-1:0] amt, amt_p, amt_z;
  logic             rs, z_big, same, carry, z_ge, s_sel, zero_sel;
  logic [LZ_W-1:0]  lz;
  res_t             res_d, res_q;
  logic             valid_q;

  fma_prod u_prod (
    .x_sig_i (x_sig_i), .y_sig_i (y_sig_i),
    .x_exp_i (exp_t'(x_exp_i)), .y_exp_i (exp_t'(y_exp_i)),
    .prod_o  (prod_w), .exp_o (pe)
  );

  assign rs    = x_neg_i ^ y_neg_i;
  assign z_w   = {{(WORD_W-SIG_W){1'b0}}, z_sig_i} << Z_SHIFT;
  assign diff  = {z_exp_i[EXP_W-1], z_exp_i} - {pe[EXP_W-1], pe};
  assign z_big = !diff[EXP_W] && (diff != '0);
  assign amt   = diff[EXP_W] ? AMT_W'(-diff) : AMT_W'(diff);
  assign amt_p = z_big ? amt : '0;
  assign amt_z = z_big ? '0 : amt;
  assign ae    = z_big ? exp_t'(z_exp_i) : pe;

  fma_sticky_shr #(.W(WORD_W), .AW(AMT_W)) u_shr_p (.v_i(prod_w), .amt_i(amt_p), .v_o(pa));
  fma_sticky_shr #(.W(WORD_W), .AW(AMT_W)) u_shr_z (.v_i(z_w),    .amt_i(amt_z), .v_o(za));

  assign same  = (z_neg_i == rs);
  assign sum   = za + pa;
  assign carry = sum[WORD_W-1];
  assign z_ge  = (za >= pa);
  assign dif   = z_ge ? (za - pa) : (pa - za);

  fma_lzc #(.W(WORD_W-1), .CW(LZ_W)) u_lzc (.v_i(dif[WORD_W-2:0]), .cnt_o(lz));

  assign norm = dif << lz;

  always_comb begin
    zero_sel = 1'b0;
    if (z_zero_i) begin
      w_sel = prod_w; e_sel = pe; s_sel = rs;
    end else if (same) begin
      w_sel = carry ? {1'b0, sum[WORD_W-1:2], sum[1] | sum[0]} : sum;
      e_sel = ae + exp_t'({{(EXP_W-1){1'b0}}, carry});
      s_sel = rs;
    end else if (dif == '0) begin
      w_sel = '0; e_sel = '0; s_sel = rdn_i; zero_sel = 1'b1;
    end else begin
      w_sel = norm;
      e_sel = ae - exp_t'({{(EXP_W-LZ_W){1'b0}}, lz});
      s_sel = z_ge ? z_neg_i : rs;
    end
  end

  always_comb begin
    res_d.sign = s_sel;
    res_d.exp  = e_sel;
    res_d.sig  = {w_sel[LEAD:OUT_SHIFT+1], w_sel[OUT_SHIFT] | (|w_sel[OUT_SHIFT-1:0])};
    res_d.zero = zero_sel;
  end

  assign in_ready_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) res_q <= res_d;
    end
  end

  assign out_valid_o = valid_q;
  assign sign_o      = res_q.sign;
  assign exp_o       = res_q.exp;
  assign sig_o       = res_q.sig;
  assign zero_o      = res_q.zero;

  // R1
  prod_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (prod_w[LEAD] && !prod_w[WORD_W-1]));
  // R4
  align_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !z_zero_i && amt >= AMT_W'(WORD_W-1)) |-> ((z_big ? pa : za) == word_t'(1)));
  // R5
  no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> !w_sel[WORD_W-1]);
  // R7
  zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && zero_o) |-> (sig_o == '0 && exp_o == '0));
  // R8
  lead_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !zero_o) |-> sig_o[OUT_W-1]);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(sig_o) && $stable(exp_o)
                                       && $stable(sign_o) && $stable(zero_o)));
endmodule

// File: tb/fma_aan_core_tb.sv
module fma_aan_core_tb;
  logic clk = 1'b0;
  logic rst_ni;
  logic in_valid_i, in_ready_o;
  logic x_neg_i, y_neg_i, z_neg_i, z_zero_i, rdn_i;
  logic [11:0] x_exp_i, y_exp_i, z_exp_i;
  logic [23:0] x_sig_i, y_sig_i, z_sig_i;
  logic out_valid_o, out_ready_i;
  logic sign_o, zero_o;
  logic [11:0] exp_o;
  logic [26:0] sig_o;

  int checks = 0;
  int fails  = 0;
  bit stall_mode = 1'b0;
  bit hold_prev = 1'b0;
  logic [40:0] hold_val;
  logic [40:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  fma_aan_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .x_neg_i(x_neg_i), .x_exp_i(x_exp_i), .x_sig_i(x_sig_i),
    .y_neg_i(y_neg_i), .y_exp_i(y_exp_i), .y_sig_i(y_sig_i),
    .z_neg_i(z_neg_i), .z_exp_i(z_exp_i), .z_sig_i(z_sig_i),
    .z_zero_i(z_zero_i), .rdn_i(rdn_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o), .zero_o(zero_o)
  );

  function automatic logic [63:0] sshr(logic [63:0] v, int n);
    logic st = 1'b0;
    for (int i = 0; i < n && i < 70; i++) begin
      st = st | v[0];
      v  = v >> 1;
    end
    v[0] = v[0] | st;
    return v;
  endfunction

  // packed as {zero, sign, exp[11:0], sig[26:0]}
  function automatic logic [40:0] model(bit xs, int xe, logic [23:0] xm, bit ys, int ye,
                                         logic [23:0] ym, bit zs, int ze, logic [23:0] zm,
                                         bit zz, bit rd);
    logic [63:0] p, zw, v, r;
    int re, e;
    bit rs, s;
    rs = xs ^ ys;
    re = xe + ye;
    p  = (64'(xm) * 64'(ym)) << 16;
    if (p[63]) begin p = p >> 1; re++; end
    if (zz) begin
      r = sshr(p, 36);
      return {1'b0, rs, 12'(re), r[26:0]};
    end
    zw = 64'(zm) << 39;
    e  = ze;
    if (ze > re) p = sshr(p, ze - re);
    else if (re > ze) begin zw = sshr(zw, re - ze); e = re; end
    if (zs == rs) begin
      v = zw + p; s = rs;
      if (v[63]) begin v = sshr(v, 1); e++; end
    end else begin
      if (zw >= p) begin v = zw - p; s = zs; end
      else begin v = p - zw; s = rs; end
      if (v == 64'd0) return {1'b1, rd, 12'd0, 27'd0};
      while (!v[62]) begin v = v << 1; e--; end
    end
    r = sshr(v, 36);
    return {1'b0, s, 12'(e), r[26:0]};
  endfunction

  task automatic send(bit xs, int xe, logic [23:0] xm, bit ys, int ye, logic [23:0] ym,
                      bit zs, int ze, logic [23:0] zm, bit zz, bit rd, string tag);
    logic [40:0] e;
    e = model(xs, xe, xm, ys, ye, ym, zs, ze, zm, zz, rd);
    @(negedge clk);
    x_neg_i = xs; x_exp_i = 12'(xe); x_sig_i = xm;
    y_neg_i = ys; y_exp_i = 12'(ye); y_sig_i = ym;
    z_neg_i = zs; z_exp_i = 12'(ze); z_sig_i = zm;
    z_zero_i = zz; rdn_i = rd; in_valid_i = 1'b1;
    #4;
    while (!in_ready_o) begin
      @(negedge clk);
      #4;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid_i = 1'b0;
  endtask

  // monitor: drives consumer ready and scores results
  always @(negedge clk) begin
    if (rst_ni) begin
      logic [40:0] got, want;
      string tag;
      got = {zero_o, sign_o, exp_o, sig_o};
      if (hold_prev) begin
        checks++;
        if (!out_valid_o || got != hold_val) begin
          fails++;
          $display("FAIL R9 hold: valid=%0b got=%h expected=%h", out_valid_o, got, hold_val);
        end
      end
      out_ready_i = stall_mode ? ($urandom % 3 == 0) : 1'b1;
      hold_prev = out_valid_o && !out_ready_i;
      hold_val  = got;
      if (out_valid_o && out_ready_i) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected result got=%h expected=none", got);
        end else begin
          want = exp_q.pop_front();
          tag  = tag_q.pop_front();
          if (got != want) begin
            fails++;
            $display("FAIL %s: got z=%0b s=%0b e=%0d m=%h expected z=%0b s=%0b e=%0d m=%h",
                     tag, got[40], got[39], $signed(got[38:27]), got[26:0],
                     want[40], want[39], $signed(want[38:27]), want[26:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; in_valid_i = 1'b0; out_ready_i = 1'b1;
    x_neg_i = 0; y_neg_i = 0; z_neg_i = 0; z_zero_i = 0; rdn_i = 0;
    x_exp_i = '0; y_exp_i = '0; z_exp_i = '0;
    x_sig_i = 24'h800000; y_sig_i = 24'h800000; z_sig_i = 24'h800000;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || in_ready_o !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: valid=%0b ready=%0b expected valid=0 ready=1", out_valid_o, in_ready_o);
    end
    rst_ni = 1'b1;

    // R1 R2: product only, both normalization paths, sticky from low product bits
    send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, "R2 one times one");
    send(0, 3, 24'hFFFFFF, 0, -2, 24'hFFFFFF, 0, 0, 24'h800000, 1, 0, "R1 product carry");
    send(1, 5, 24'hFFFFFF, 0, 7, 24'h800001, 0, 0, 24'h800000, 1, 0, "R2 negative sticky");
    // R5 equal signs
    send(0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, "R5 add carry");
    send(1, 2, 24'hC00000, 0, 1, 24'hA00000, 1, 1, 24'h900001, 0, 0, "R5 add negative");
    // R3 alignment either way
    send(0, 0, 24'h800000, 0, 0, 24'h800003, 0, 5, 24'h800000, 0, 0, "R3 z larger");
    send(0, 2, 24'h812345, 0, 2, 24'h800000, 0, -3, 24'hFFFFFF, 0, 0, "R3 product larger");
    // R4 shift distance boundaries
    send(0, 0, 24'h800000, 0, 0, 24'h800001, 0, 62, 24'h800000, 0, 0, "R4 distance 62");
    send(0, 0, 24'h800000, 0, 0, 24'h800001, 0, 63, 24'h800000, 0, 0, "R4 distance 63");
    send(0, 0, 24'h800000, 0, 0, 24'h800001, 1, 100, 24'h800000, 0, 0, "R4 distance 100 sub");
    send(0, 40, 24'h800000, 0, 40, 24'h800000, 1, 0, 24'hFFFFFF, 0, 0, "R4 z far below");
    // R6 differing signs
    send(0, 0, 24'h800000, 0, 0, 24'h800000, 1, 0, 24'hC00000, 0, 0, "R6 z larger");
    send(1, 0, 24'hC00000, 0, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, "R6 product larger");
    // R7 exact cancellation in both modes
    send(0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, "R7 zero nearest");
    send(0, 0, 24'h800000, 1, 0, 24'h800000, 0, 0, 24'h800000, 0, 1, "R7 zero round-down");
    // R8 deep cancellation
    send(1, 0, 24'h800000, 0, 0, 24'h800000, 0, 0, 24'h800001, 0, 0, "R8 one lsb left");
    send(0, -1, 24'hFFFFFF, 0, 1, 24'h800000, 1, 0, 24'hFFFFFE, 0, 0, "R8 cancel product side");

    // random operands, then with consumer stalls (R9)
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      for (int i = 0; i < 300; i++) begin
        int xe, ye, ze;
        xe = int'($urandom % 61) - 30;
        ye = int'($urandom % 61) - 30;
        ze = xe + ye + int'($urandom % 141) - 70;
        send($urandom % 2, xe, 24'h800000 | 24'($urandom), $urandom % 2, ye,
             24'h800000 | 24'($urandom), $urandom % 2, ze,
             (i % 7 == 0) ? 24'h800000 : (24'h800000 | 24'($urandom)),
             ($urandom % 8 == 0), $urandom % 2,
             stall_mode ? "R9 random stalled" : "R6 random");
      end
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule